// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block finds out whether the receive wire pair of a twisted-pair port has been swapped and, if so, inverts the recovered serial bit before it reaches the line decoder. It works on digital events that an analog front end has already qualified. These events are link-pulse strobes, each tagged with its sign. There is a frame-end strobe that carries the sign of the end delimiter. A link-pass level comes from the link monitor.

While the link monitor reports a failed link, every link pulse is passed on, and the signs of the most recent pulses are recorded. When the link turns to pass, a majority vote over that record sets the invert register. From then on, only pulses of the learned sign get through. Valid frames refine the decision. A run of consecutive end delimiters of the opposite sign flips the register, and a single bad delimiter does not. Each new link failure clears the record and the vote, so detection is armed again.

Top module: `rxpol_correct`

## Requirements
- R1: After reset `pol_inv` is 0, the link is taken as failed, and the pulse record and frame vote are empty.
- R2: While `link_pass` is 0, `pulse_ok` equals `pulse_stb` in the same cycle, whatever the value of `pulse_neg` (1 = negative pulse).
- R3: While `link_pass` is 0, each pulse strobe shifts its sign into a record of the last RUN_LEN (default 5) signs. In the cycle after `link_pass` rises, `pol_inv` is 1 if more than half of the recorded signs are negative. It is 0 if fewer than half are negative. It is unchanged on a tie or an empty record.
- R4: While `link_pass` is 1, `pulse_ok` is 1 only when `pulse_stb` is 1 and `pulse_neg` equals `pol_inv`.
- R5: When `link_pass` falls, the record is cleared, so pulses seen before that cycle take no part in the next vote. A pulse in the falling cycle itself is the first entry of the new record.
- R6: While `link_pass` is 1, a frame-end strobe whose `frame_end_neg` differs from `pol_inv` counts as a mismatch. A matching one clears the count. At the CONFIRM-th (default 2) consecutive mismatch, `pol_inv` toggles in the next cycle and the count restarts.
- R7: Frame-end strobes while `link_pass` is 0, or in the cycle `link_pass` rises, are ignored. Any change of `link_pass` clears the mismatch count.
- R8: `rx_bit_out` equals `rx_bit_raw` XOR `pol_inv`, with no register delay.
- R9: `pol_inv` changes only at a pass entry (R3) or a frame-confirmed toggle (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| link_pass | input | 1 | Link state from the monitor: 1 pass, 0 fail |
| pulse_stb | input | 1 | One-cycle strobe of a qualified link pulse |
| pulse_neg | input | 1 | Sign of that pulse: 1 negative, 0 positive |
| frame_end_stb | input | 1 | One-cycle strobe of a valid end delimiter |
| frame_end_neg | input | 1 | Sign of that delimiter on the uncorrected pair |
| rx_bit_raw | input | 1 | Received serial bit before correction |
| rx_bit_out | output | 1 | Corrected bit toward the decoder |
| pulse_ok | output | 1 | Filtered link-pulse strobe |
| pol_inv | output | 1 | Current invert setting |

## Verification
A wrong record or a wrong majority appears on `pol_inv` in the cycle after link pass is entered. It then appears at once on `rx_bit_out` and on which pulse signs `pulse_ok` lets through. A mismatch count that is off shows up as a toggle that comes one frame too early or too late, or that is never cleared by a matching frame. A record that is not cleared on link failure shows up only at the next pass entry, so the sweep re-arms with pre-loaded pulses before every pattern. The sweep covers every sign pattern of zero to six pulses, so ties, empty records and overflow of the record are all reached.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

  // Majority decision over recorded pulse signs; ties and empty keep current.
  function automatic logic f_learn(input int unsigned neg_n,
                                   input int unsigned tot_n,
                                   input logic cur);
    if (2 * neg_n > tot_n)      return 1'b1;
    else if (2 * neg_n < tot_n) return 1'b0;
    else                        return cur;
  endfunction

  // Acceptance of a pulse sign given the link state and the learned setting.
  function automatic logic f_sign_ok(input logic link_up,
                                     input logic neg,
                                     input logic inv);
    return !link_up || (neg == inv);
  endfunction

endpackage

// File: rtl/rxpol_pulse_hist.sv
module rxpol_pulse_hist #(
  parameter int RUN_LEN = 5,
  parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             neg,
  output logic [CNT_W-1:0] tot_n,
  output logic [CNT_W-1:0] neg_n
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [RUN_LEN-1:0] sign_q, sign_base, sign_d;
  logic [CNT_W-1:0]   cnt_q, cnt_base, cnt_d;

  always_comb begin
    sign_base = clear ? '0 : sign_q;
    cnt_base  = clear ? '0 : cnt_q;
    sign_d    = sign_base;
    cnt_d     = cnt_base;
    if (take) begin
      sign_d = {sign_base[RUN_LEN-2:0], neg};
      if (cnt_base != FULL) cnt_d = cnt_base + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= '0;
      cnt_q  <= '0;
    end else begin
      sign_q <= sign_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tot_n = cnt_q;
  assign neg_n = CNT_W'($countones(sign_q));

  AST_HIST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q <= 1)); // R5
  AST_HIST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= FULL) && (neg_n <= cnt_q)); // R3
endmodule

// File: rtl/rxpol_frame_vote.sv
module rxpol_frame_vote #(
  parameter int CONFIRM = 2,
  parameter int VOTE_W  = $clog2(CONFIRM + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic frame_stb,
  input  logic mismatch,
  output logic flip
);
  localparam logic [VOTE_W-1:0] LAST = VOTE_W'(CONFIRM - 1);

  logic [VOTE_W-1:0] cnt_q, cnt_d;

  assign flip = !clear && frame_stb && mismatch && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                      cnt_d = '0;
    else if (frame_stb && mismatch) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    else if (frame_stb)             cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_VOTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6
  AST_VOTE_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !mismatch) |=> (cnt_q == '0)); // R6
  AST_VOTE_LINK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/rxpol_gate.sv
module rxpol_gate
  import rxpol_pkg::*;
(
  input  logic link_up,
  input  logic inv,
  input  logic pulse_stb,
  input  logic pulse_neg,
  input  logic bit_raw,
  output logic pulse_ok,
  output logic bit_out
);
  assign pulse_ok = pulse_stb && f_sign_ok(link_up, pulse_neg, inv);
  assign bit_out  = bit_raw ^ inv;
endmodule

// File: rtl/rxpol_correct.sv
module rxpol_correct
  import rxpol_pkg::*;
#(
  parameter int RUN_LEN = 5,
  parameter int CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_pass,
  input  logic pulse_stb,
  input  logic pulse_neg,
  input  logic frame_end_stb,
  input  logic frame_end_neg,
  input  logic rx_bit_raw,
  output logic rx_bit_out,
  output logic pulse_ok,
  output logic pol_inv
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);

  logic             link_q;
  logic             pass_entry, fail_entry, link_edge;
  logic             vote_flip, learned;
  logic [CNT_W-1:0] hist_tot, hist_neg;

  assign pass_entry = link_pass && !link_q;
  assign fail_entry = !link_pass && link_q;
  assign link_edge  = pass_entry || fail_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_pass;
  end

  rxpol_pulse_hist #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fail_entry),
    .take  (pulse_stb && !link_pass),
    .neg   (pulse_neg),
    .tot_n (hist_tot),
    .neg_n (hist_neg)
  );

  rxpol_frame_vote #(.CONFIRM(CONFIRM)) u_vote (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (link_edge),
    .frame_stb (frame_end_stb && link_pass),
    .mismatch  (frame_end_neg != pol_inv),
    .flip      (vote_flip)
  );

  assign learned = f_learn(int'(hist_neg), int'(hist_tot), pol_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pol_inv <= 1'b0;
    else if (pass_entry) pol_inv <= learned;
    else if (vote_flip)  pol_inv <= ~pol_inv;
  end

  rxpol_gate u_gate (
    .link_up   (link_pass),
    .inv       (pol_inv),
    .pulse_stb (pulse_stb),
    .pulse_neg (pulse_neg),
    .bit_raw   (rx_bit_raw),
    .pulse_ok  (pulse_ok),
    .bit_out   (rx_bit_out)
  );

  AST_FAIL_PASSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !link_pass |-> (pulse_ok == pulse_stb)); // R2
  AST_PASS_LEARNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (link_pass && pulse_ok) |-> (pulse_neg == pol_inv)); // R4
  AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_entry && !vote_flip) |=> $stable(pol_inv)); // R9
  AST_FLIP_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    vote_flip |-> (link_pass && link_q && frame_end_stb)); // R7
  AST_FLIP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    vote_flip |=> (pol_inv != $past(pol_inv))); // R6
endmodule

// File: tb/rxpol_correct_tb.sv
`timescale 1ns/1ps
module rxpol_correct_tb;
  localparam int RUN_LEN = 5;
  localparam int CONFIRM = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_pass = 0, pulse_stb = 0, pulse_neg = 0;
  logic frame_end_stb = 0, frame_end_neg = 0, rx_bit_raw = 0;
  logic rx_bit_out, pulse_ok, pol_inv;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic m_inv = 0, m_lq = 0;
  logic [RUN_LEN-1:0] m_sign = '0;
  int m_cnt = 0, m_vote = 0;

  always #2.5 clk = ~clk;

  rxpol_correct #(.RUN_LEN(RUN_LEN), .CONFIRM(CONFIRM)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_pass(link_pass), .pulse_stb(pulse_stb),
    .pulse_neg(pulse_neg), .frame_end_stb(frame_end_stb),
    .frame_end_neg(frame_end_neg), .rx_bit_raw(rx_bit_raw),
    .rx_bit_out(rx_bit_out), .pulse_ok(pulse_ok), .pol_inv(pol_inv));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check outputs, then advance the model at posedge.
  task automatic cyc(input logic lk, input logic ps, input logic pn,
                     input logic fs, input logic fn, input logic raw);
    int nn;
    logic pe, fe;
    @(negedge clk);
    link_pass = lk; pulse_stb = ps; pulse_neg = pn;
    frame_end_stb = fs; frame_end_neg = fn; rx_bit_raw = raw;
    #1;
    chk("R3 R6 R9 pol_inv", pol_inv, m_inv);
    chk("R8 rx_bit_out", rx_bit_out, raw ^ m_inv);
    if (!lk) chk("R2 pulse_ok fail", pulse_ok, ps);
    else     chk("R4 pulse_ok pass", pulse_ok, ps && (pn == m_inv));
    @(posedge clk);
    pe = lk && !m_lq;
    fe = !lk && m_lq;
    if (pe) begin
      nn = $countones(m_sign);
      if (2 * nn > m_cnt)      m_inv = 1'b1;
      else if (2 * nn < m_cnt) m_inv = 1'b0;
    end
    if (fe) begin m_sign = '0; m_cnt = 0; end   // R5
    if (!lk && ps) begin
      m_sign = {m_sign[RUN_LEN-2:0], pn};
      if (m_cnt < RUN_LEN) m_cnt++;
    end
    if (pe || fe) m_vote = 0;                    // R7
    else if (lk && fs) begin
      if (fn != m_inv) begin
        if (m_vote == CONFIRM - 1) begin m_vote = 0; m_inv = ~m_inv; end
        else m_vote++;
      end else m_vote = 0;
    end
    m_lq = lk;
  endtask

  task automatic idle(input logic lk);
    cyc(lk, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 pol_inv after reset", pol_inv, 1'b0);
    chk("R1 pulse_ok idle", pulse_ok, 1'b0);
    rst_n = 1'b1;
    // R1: empty record, pass entry keeps 0
    idle(0); idle(1);
    chk("R1 empty record keeps", pol_inv, 1'b0);
    idle(1); idle(0);

    for (int len = 0; len <= 6; len++) begin
      for (int p = 0; p < (1 << len); p++) begin
        // stale pulses of opposite majority, then re-arm (R5)
        cyc(0, 1, ~p[0], 0, 0, 0);
        cyc(0, 1, ~p[0], 1, 1, 1);   // frame in fail ignored (R7)
        cyc(1, 0, 0, 1, ~m_inv, 0);  // frame in pass-entry cycle ignored (R7)
        cyc(0, 0, 0, 0, 0, 1);       // fail entry clears record (R5)
        for (int i = 0; i < len; i++) begin
          cyc(0, 1, p[i], 0, 0, p[i]);
          cyc(0, 0, 0, 0, 0, ~p[i]);
        end
        idle(1);                      // pass entry: learn (R3)
        cyc(1, 1, 0, 0, 0, 1);        // R4 positive pulse
        cyc(1, 1, 1, 0, 0, 0);        // R4 negative pulse
        // R6: mismatch, match, mismatch, mismatch -> toggle
        cyc(1, 0, 0, 1, ~m_inv, 0);
        cyc(1, 0, 0, 1,  m_inv, 1);
        cyc(1, 0, 0, 1, ~m_inv, 0);
        cyc(1, 0, 0, 1, ~m_inv, 1);
        cyc(1, 1, p[0], 0, 0, 1);     // filter uses toggled setting
        cyc(1, 0, 0, 1, ~m_inv, 0);   // one mismatch, then fail clears count
        idle(0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, ~m_inv, 0);   // single mismatch after re-entry: no toggle
        idle(1);
        idle(0);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule